// File: doc/BRIEF.md
# ROM Table-Lookup Sequencer

This block is the execution slice of a small 4-bit controller that reads a constant table out of program memory. When an instruction with the top four bits `0010` is accepted, it borrows one level of the return stack to park the program counter. It then forms a 14-bit ROM address from a bank-extended page and the contents of registers D and A, and reads one ROM word. The low byte of that word is split between registers B and A. Finally the counter is restored by popping the stack. The whole lookup takes three machine cycles.

A bank bit selects the upper or lower half of the page space. Dedicated strobes set and clear it, and reset or a wake from power-down returns it to the lower half. The block also carries the single-cycle companion transfer that copies D into the low bits of A. That transfer is opcode `10'h051`, and it clears bit 3 of A. A parameter bounds the valid page number. A lookup beyond that bound returns zero and raises an error pulse. The ROM, the stack storage and the register file sit outside the block and connect through write enables and request strobes.

Top module: `rom_table_seq`

## Requirements
- R1: A lookup starts only when `instr_valid` is high, `instr[9:6]` equals `4'b0010` and the block is idle. Any other opcode starts nothing, and `busy` stays low.
- R2: In lookup cycle 1, `rom_re` is high and `rom_addr` equals `{bank, instr[5:0], reg_d[2:0], reg_a[3:0]}`, most significant bit first. These values are sampled at acceptance.
- R3: In cycle 1, `push_req` is high with `push_data` equal to `pc_in`, and `pc_we` loads `rom_addr` into the program counter.
- R4: In cycle 3, `b_we` and `a_we` are high, with `b_wdata` equal to ROM bits 7..4 and `a_wdata` equal to ROM bits 3..0. ROM data is valid one cycle after `rom_re`.
- R5: In cycle 3, `pop_req` and `pc_we` are high and `pc_wdata` equals `pop_data`, which restores the saved counter.
- R6: `busy` is high for exactly three cycles, and `done` pulses in the third cycle only. Instructions presented while busy are ignored. This includes the D-to-A transfer, which produces no `a_we` during that time.
- R7: `bank_set` sets the bank bit and `bank_clr` clears it. If both are high, clear wins. Reset and `wake` also clear it.
- R8: If the effective page (bank times 64 plus the page field) exceeds `MAX_PAGE`, `page_err` pulses in cycle 3 and both A and B are written with 0.
- R9: `stk_ovf` is high in cycle 1 when `stk_depth` already equals `STACK_DEPTH`, so the borrowed push has no free level.
- R10: Opcode `10'h051` while idle writes A in the same cycle with `a_wdata = {1'b0, reg_d}`, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake | input | 1 | Return from power-down; clears bank |
| bank_set | input | 1 | Select upper page half |
| bank_clr | input | 1 | Select lower page half |
| instr_valid | input | 1 | Instruction present |
| instr | input | 10 | Instruction word |
| reg_a | input | 4 | Accumulator value |
| reg_d | input | 3 | D register value |
| pc_in | input | 14 | Current program counter |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | 14 | ROM read address |
| rom_data | input | 10 | ROM word, one cycle after read |
| push_req | output | 1 | Stack push |
| push_data | output | 14 | Value pushed |
| pop_req | output | 1 | Stack pop |
| pop_data | input | 14 | Top of stack |
| stk_depth | input | 4 | Occupied stack levels |
| stk_ovf | output | 1 | Push beyond top level |
| pc_we | output | 1 | Program counter write |
| pc_wdata | output | 14 | Program counter value |
| a_we | output | 1 | Accumulator write |
| a_wdata | output | 4 | Accumulator value |
| b_we | output | 1 | B register write |
| b_wdata | output | 4 | B register value |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Lookup completes this cycle |
| page_err | output | 1 | Page beyond limit |

## Verification
The bench targets the bank bit's priority and its clearing by wake. A design that got these wrong would fetch from the wrong half of memory, and that shows up in the high address bit. It looks for the one-cycle ROM latency: sampling data too early would put stale bytes into A and B. It confirms that the counter returned in cycle 3 is the value pushed rather than the table address. It drives pages past the limit, where a design missing the check would return real ROM data. It fills the stack to the top, where a missing flag would silently lose a return address. It also presents the D-to-A transfer while a lookup is busy, which a careless design would wrongly execute.

// File: rtl/rom_table_seq.sv
module rom_table_seq #(
  parameter int PAGE_W      = 6,
  parameter int ROM_W       = 10,
  parameter int STACK_DEPTH = 8,
  parameter int MAX_PAGE    = 95,
  localparam int LOW_W  = 7,
  localparam int ADDR_W = PAGE_W + 1 + LOW_W,
  localparam int DEP_W  = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake,
  input  logic              bank_set,
  input  logic              bank_clr,
  input  logic              instr_valid,
  input  logic [9:0]        instr,
  input  logic [3:0]        reg_a,
  input  logic [2:0]        reg_d,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              rom_re,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [ROM_W-1:0]  rom_data,
  output logic              push_req,
  output logic [ADDR_W-1:0] push_data,
  output logic              pop_req,
  input  logic [ADDR_W-1:0] pop_data,
  input  logic [DEP_W-1:0]  stk_depth,
  output logic              stk_ovf,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wdata,
  output logic              a_we,
  output logic [3:0]        a_wdata,
  output logic              b_we,
  output logic [3:0]        b_wdata,
  output logic              busy,
  output logic              done,
  output logic              page_err
);
  localparam logic [1:0] IDLE = 2'd0, CYC1 = 2'd1, CYC2 = 2'd2, CYC3 = 2'd3;
  localparam logic [PAGE_W:0] PAGE_LIM = MAX_PAGE[PAGE_W:0];
  localparam logic [DEP_W-1:0] DEP_TOP = STACK_DEPTH[DEP_W-1:0];

  logic [1:0]        st;
  logic              bank_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  wire idle     = (st == IDLE);
  wire is_look  = (instr[9:6] == 4'b0010);
  wire is_xfer  = (instr == 10'h051);
  wire start    = idle && instr_valid && is_look;
  wire xfer     = idle && instr_valid && is_xfer;
  wire [PAGE_W:0] page_eff = {bank_q, instr[PAGE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      bank_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bank_clr || wake) bank_q <= 1'b0;
      else if (bank_set)    bank_q <= 1'b1;
      case (st)
        IDLE: if (start) begin
          st     <= CYC1;
          addr_q <= {page_eff, reg_d, reg_a};
          err_q  <= (page_eff > PAGE_LIM);
        end
        CYC1: st <= CYC2;
        CYC2: begin
          st     <= CYC3;
          data_q <= rom_data[7:0];
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign done      = (st == CYC3);
  assign rom_re    = (st == CYC1);
  assign rom_addr  = addr_q;
  assign push_req  = (st == CYC1);
  assign push_data = pc_in;
  assign stk_ovf   = push_req && (stk_depth >= DEP_TOP);
  assign pop_req   = done;
  assign pc_we     = push_req || done;
  assign pc_wdata  = done ? pop_data : addr_q;
  assign page_err  = done && err_q;
  assign b_we      = done;
  assign b_wdata   = err_q ? 4'h0 : data_q[7:4];
  assign a_we      = done || xfer;
  assign a_wdata   = done ? (err_q ? 4'h0 : data_q[3:0]) : {1'b0, reg_d};

  // R5
  pc_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_wdata == $past(push_data, 2));

  // R6
  three_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(push_req, 2) && busy);

  // R4
  write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> a_we && b_we && pop_req);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> a_wdata == 4'h0 && b_wdata == 4'h0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> push_req);

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> push_req && rom_re);
endmodule

// File: tb/rom_table_seq_test.sv
module rom_table_seq_test;
  logic clk = 0, rst_n = 0, wake = 0, bank_set = 0, bank_clr = 0, instr_valid = 0;
  logic [9:0] instr = '0;
  logic [3:0] reg_a = '0;
  logic [2:0] reg_d = '0;
  logic [13:0] pc_in = '0, rom_addr, push_data, pop_data, pc_wdata;
  logic [9:0] rom_data = '0;
  logic [3:0] stk_depth, a_wdata, b_wdata;
  logic rom_re, push_req, pop_req, stk_ovf, pc_we, a_we, b_we, busy, done, page_err;
  logic [13:0] stk [0:8];
  int depth = 0, checks = 0, fails = 0, bank_m = 0;

  always #2 clk = ~clk;

  rom_table_seq uut (.*);

  function automatic logic [9:0] romf(input logic [13:0] ad);
    return {2'b01, ad[7:0] ^ ad[13:6]};
  endfunction

  assign stk_depth = 4'(depth);
  assign pop_data  = (depth > 0) ? stk[depth-1] : 14'h0;

  always @(posedge clk) begin
    if (rom_re) rom_data <= romf(rom_addr);
    if (push_req) begin stk[depth] <= push_data; depth <= depth + 1; end
    if (pop_req) depth <= depth - 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bank_op(input int op);
    @(negedge clk);
    bank_set = (op == 1); bank_clr = (op == 2);
    @(negedge clk);
    bank_set = 0; bank_clr = 0;
    if (op == 1) bank_m = 1;
    if (op == 2) bank_m = 0;
  endtask

  task automatic lookup(input logic [5:0] p, input logic [3:0] a, input logic [2:0] d,
                        input logic [13:0] pc);
    logic [13:0] ad;
    logic [9:0] w;
    bit err, ovf;
    ad  = {1'(bank_m), p, d, a};
    w   = romf(ad);
    err = (bank_m * 64 + p) > 95;
    ovf = (depth >= 8);
    @(negedge clk);
    instr = {4'b0010, p}; instr_valid = 1; reg_a = a; reg_d = d; pc_in = pc;
    @(negedge clk);
    instr_valid = 0;
    check("R2 rom_addr", rom_addr, ad);
    check("R2 rom_re", rom_re, 1);
    check("R3 push", {push_req, push_data}, {1'b1, pc});
    check("R3 pc load", {pc_we, pc_wdata}, {1'b1, ad});
    check("R9 ovf", stk_ovf, ovf);
    reg_a = ~a;
    instr = 10'h051; instr_valid = 1;
    @(negedge clk);
    check("R6 cyc2", {busy, done, a_we}, 3'b100);
    instr_valid = 0;
    @(negedge clk);
    check("R6 cyc3", {busy, done}, 2'b11);
    check("R4 b", {b_we, b_wdata}, {1'b1, err ? 4'h0 : w[7:4]});
    check("R4 a", {a_we, a_wdata}, {1'b1, err ? 4'h0 : w[3:0]});
    check("R5 restore", {pop_req, pc_we, pc_wdata}, {2'b11, pc});
    check("R8 err", page_err, err);
    @(negedge clk);
    check("R6 idle", {busy, done}, 2'b00);
    if (ovf) depth = depth - 1;
  endtask

  localparam logic [28:0] VEC [8] = '{
    {2'd0, 6'd0,  4'h0, 3'd0, 14'h0100},
    {2'd0, 6'd63, 4'hF, 3'd7, 14'h3FFF},
    {2'd0, 6'd21, 4'h5, 3'd2, 14'h1234},
    {2'd1, 6'd10, 4'hA, 3'd5, 14'h0ABC},
    {2'd0, 6'd31, 4'h3, 3'd6, 14'h2001},
    {2'd0, 6'd32, 4'h9, 3'd1, 14'h0777},
    {2'd2, 6'd45, 4'hC, 3'd3, 14'h1F0F},
    {2'd3, 6'd12, 4'h6, 3'd4, 14'h00AA}
  };

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R6 reset busy", {busy, done, a_we, b_we, pc_we, push_req}, 6'b0);
        rst_n = 1;
        foreach (VEC[i]) begin
          if (VEC[i][28:27] == 2'd3) begin
            bank_op(1);
            @(negedge clk); wake = 1; @(negedge clk); wake = 0; bank_m = 0; // R7 wake
          end else if (VEC[i][28:27] != 0) bank_op(int'(VEC[i][28:27]));
          lookup(VEC[i][26:21], VEC[i][20:17], VEC[i][16:14], VEC[i][13:0]);
        end
        // R7 clear has priority over set
        bank_op(1);
        @(negedge clk); bank_set = 1; bank_clr = 1;
        @(negedge clk); bank_set = 0; bank_clr = 0; bank_m = 0;
        lookup(6'd3, 4'h1, 3'd2, 14'h0042);
        // R8 page beyond limit
        bank_op(1);
        lookup(6'd40, 4'h7, 3'd7, 14'h0300);
        lookup(6'd31, 4'h2, 3'd0, 14'h0301);
        bank_op(2);
        // R9 stack full
        depth = 8;
        lookup(6'd5, 4'h4, 3'd4, 14'h0555);
        depth = 0;
        // R10 transfer from D to A
        @(negedge clk);
        reg_d = 3'd6; reg_a = 4'hF; instr = 10'h051; instr_valid = 1;
        #1;
        check("R10 xfer", {a_we, a_wdata, busy}, {1'b1, 4'h6, 1'b0});
        @(negedge clk);
        instr_valid = 0;
        check("R10 no busy", busy, 0);
        // R1 other opcode starts nothing
        instr = 10'h0C5; instr_valid = 1;
        @(negedge clk);
        instr_valid = 0;
        check("R1 no start", {busy, push_req, rom_re}, 3'b0);
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule